// File: doc/BRIEF.md
# Serial Bus Status Read Target

This block is the target side of a two-wire serial bus (I2C) for a frequency synthesizer control chip, and it handles reads only. It watches the clock and data lines, synchronised to a local system clock. It detects START and STOP conditions and collects an 8-bit address byte. When that byte names this chip and asks for a read, the block acknowledges it.

After the acknowledge, the block shifts out a one-byte status word, most significant bit first. The word holds a sticky power-on flag, a lock indication, three port input levels and a 3-bit converter code. The controller can keep reading: each time it acknowledges a status byte, a freshly sampled copy follows. When it does not acknowledge, the block lets go of the data line so that the controller can finish with STOP.

The power-on flag is set at reset and while a supply-low input is asserted. Only a STOP that ends a read clears it.

Top module: `i2c_status_target`

## Requirements
- R1: The block acknowledges an address byte (data line driven low during the ninth clock) when bits 7:1 equal {5'b11000, addr_sel[1:0]} and bit 0 is 1. With addr_sel = 0, 1, 2, 3 this gives address bytes 0xC1, 0xC3, 0xC5 and 0xC7.
- R2: The block never drives the data line for an address byte whose bits 7:1 do not match, or whose bit 0 is 0 (a write). This holds until the next START.
- R3: The data output enable changes only while the synchronised clock line is low.
- R4: The status byte is {por, lock_in, port_lvl[2:0], conv_code[2:0]}, with bit 7 sent first. Each byte is sampled when its transmission begins.
- R5: An acknowledge from the controller after a status byte makes the block send the status byte again, sampled afresh.
- R6: A missing acknowledge after a status byte makes the block release the data line for all later clocks. A STOP also leaves the data line released.
- R7: The power-on flag reads 1 after reset, and again on the cycle after supply_low has been seen high.
- R8: Only a STOP that ends a read which reached the data phase clears the power-on flag. A STOP after a write or after an unmatched address leaves it at 1.
- R9: A START at any point, including in the middle of a byte, restarts address reception from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 2 | Address select straps |
| supply_low | input | 1 | Supply-low indication, sets the power-on flag |
| lock_in | input | 1 | Loop lock indication |
| port_lvl | input | 3 | Port input levels |
| conv_code | input | 3 | Converter output code |

## Verification
The hardest state to reach is the clearing of the sticky power-on flag. It needs a complete read that reaches the data phase and is then closed by a STOP. STOPs after writes, after unmatched addresses and after supply-low pulses must all leave the flag alone. A walked table orders the transfers so that unmatched and write addresses run before the first valid read, and the bench models the flag. Directed sequences then pulse supply_low, change the inputs between repeated bytes, and break an address with a repeated START.

// File: rtl/i2c_status_pkg.sv
package i2c_status_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_AACK = 3'd2,
    ST_TX   = 3'd3,
    ST_TACK = 3'd4
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
endmodule

// File: rtl/i2c_por_flag.sv
module i2c_por_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic flag_n;

  always_comb begin
    flag_n = flag_q;
    if (set_i)      flag_n = 1'b1;
    else if (clr_i) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= flag_n;
  end
endmodule

// File: rtl/i2c_status_target.sv
module i2c_status_target
  import i2c_status_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int PORT_W      = 3,
  parameter int CONV_W      = 3,
  parameter int ADDR_PREFIX = 'h18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic              supply_low,
  input  logic              lock_in,
  input  logic [PORT_W-1:0] port_lvl,
  input  logic [CONV_W-1:0] conv_code
);
  localparam int BYTE_W = 2 + PORT_W + CONV_W;
  localparam int PFX_W  = BYTE_W - 1 - SEL_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic scl_s, sda_s;
  i2c_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_core_n),
    .din ({scl_i, sda_i}), .dout ({scl_s, sda_s})
  );

  logic start_det, stop_det, scl_rise, scl_fall;
  i2c_bus_events u_evt (
    .clk (clk), .rst_n (rst_core_n), .scl_s (scl_s), .sda_s (sda_s),
    .start_det (start_det), .stop_det (stop_det),
    .scl_rise (scl_rise), .scl_fall (scl_fall)
  );

  tgt_state_t        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              ack_q, ack_n;
  logic              act_q, act_n;
  logic              por_q;
  logic [BYTE_W-1:0] status_w;
  logic              addr_hit;

  i2c_por_flag u_por (
    .clk (clk), .rst_n (rst_core_n),
    .set_i (supply_low), .clr_i (stop_det & act_q),
    .flag_q (por_q)
  );

  assign status_w = {por_q, lock_in, port_lvl, conv_code};
  assign addr_hit = (sh_q[BYTE_W-1:1] == {PFX_W'(ADDR_PREFIX), addr_sel}) & sh_q[0];

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    ack_n = ack_q;
    act_n = act_q;
    if (start_det) begin
      st_n  = ST_ADDR;
      cnt_n = '0;
      act_n = 1'b0;
    end else if (stop_det) begin
      st_n  = ST_IDLE;
      act_n = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != CNT_W'(BYTE_W)) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            st_n = addr_hit ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            st_n  = ST_TX;
            sh_n  = status_w;
            cnt_n = '0;
            act_n = 1'b1;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            sh_n  = {sh_q[BYTE_W-2:0], 1'b0};
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(BYTE_W - 1)) st_n = ST_TACK;
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            ack_n = ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              st_n  = ST_TX;
              sh_n  = status_w;
              cnt_n = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      ack_q <= ack_n;
      act_q <= act_n;
    end
  end

  assign sda_oe = (st_q == ST_AACK) | ((st_q == ST_TX) & ~sh_q[BYTE_W-1]);
endmodule

// File: rtl/i2c_status_target_chk.sv
module i2c_status_target_chk (
  input logic clk,
  input logic rst_core_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic supply_low,
  input logic por_q,
  input logic sda_oe
);
  assert_sda_hold_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  assert_por_set_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    supply_low |=> por_q);

  assert_por_clear_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(por_q) |-> $past(stop_det));

  assert_release_stop_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    stop_det |=> !sda_oe);

  assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    start_det |=> !sda_oe);
endmodule

bind i2c_status_target i2c_status_target_chk u_chk (
  .clk (clk), .rst_core_n (rst_core_n), .scl_s (scl_s),
  .start_det (start_det), .stop_det (stop_det), .supply_low (supply_low),
  .por_q (por_q), .sda_oe (sda_oe)
);

// File: tb/sim_i2c_status_target.sv
module sim_i2c_status_target;
  localparam int Q = 10;
  localparam int NV = 7;
  // {sel[1:0], addr[7:0], lock, port[2:0], conv[2:0], exp_ack}
  localparam logic [17:0] VEC [NV] = '{
    {2'd2, 8'hC1, 1'b1, 3'b101, 3'd2, 1'b0},
    {2'd2, 8'hC4, 1'b0, 3'b011, 3'd4, 1'b0},
    {2'd2, 8'hC5, 1'b1, 3'b110, 3'd1, 1'b1},
    {2'd0, 8'hC1, 1'b0, 3'b001, 3'd3, 1'b1},
    {2'd1, 8'hC3, 1'b1, 3'b111, 3'd0, 1'b1},
    {2'd3, 8'hC7, 1'b0, 3'b010, 3'd4, 1'b1},
    {2'd3, 8'hC3, 1'b1, 3'b100, 3'd7, 1'b0}
  };

  logic clk, rst_n, scl, sda_m, sda_oe, supply_low, lock_in;
  logic [1:0] addr_sel;
  logic [2:0] port_lvl, conv_code;
  logic sda_bus;
  int n_chk, n_fail;
  logic por_m;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_status_target u0 (
    .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_bus), .sda_oe (sda_oe),
    .addr_sel (addr_sel), .supply_low (supply_low), .lock_in (lock_in),
    .port_lvl (port_lvl), .conv_code (conv_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0;
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q/2); acked = ~sda_bus; wt(Q/2); scl = 1'b0;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b, output logic oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q/2); b[i] = sda_bus;
      oe_seen = oe_seen | sda_oe; wt(Q/2); scl = 1'b0;
    end
    sda_m = ~give_ack; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(1); sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ak, oe;
    logic [7:0] rb;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; supply_low = 1'b0;
    lock_in = 1'b0; port_lvl = '0; conv_code = '0; addr_sel = '0;
    por_m = 1'b1;
    wt(5); rst_n = 1'b1; wt(10);
    chk("R6 reset released", int'(sda_oe), 0);

    // table walk: R1 R2 R4 R8
    for (int v = 0; v < NV; v++) begin
      addr_sel = VEC[v][17:16]; lock_in = VEC[v][7];
      port_lvl = VEC[v][6:4]; conv_code = VEC[v][3:1];
      bus_start();
      send_byte(VEC[v][15:8], ak);
      chk(VEC[v][0] ? "R1 address ack" : "R2 no ack", int'(ak), int'(VEC[v][0]));
      if (VEC[v][0]) begin
        read_byte(1'b0, rb, oe);
        chk("R4 status byte", int'(rb), int'({por_m, VEC[v][7], VEC[v][6:4], VEC[v][3:1]}));
      end else begin
        wt(Q); chk("R2 released after mismatch", int'(sda_oe), 0);
      end
      bus_stop();
      chk("R6 released after stop", int'(sda_oe), 0);
      if (VEC[v][0]) por_m = 1'b0;
    end

    // R7: supply-low sets the flag; R8 read+stop clears it
    addr_sel = 2'd1; lock_in = 1'b1; port_lvl = 3'b010; conv_code = 3'd5;
    supply_low = 1'b1; wt(2); supply_low = 1'b0; wt(2);
    bus_start(); send_byte(8'hC2, ak); bus_stop();   // write: flag stays
    bus_start(); send_byte(8'hC3, ak);
    read_byte(1'b0, rb, oe);
    chk("R7 flag set by supply low", int'(rb), int'({1'b1, 1'b1, 3'b010, 3'd5}));
    bus_stop();
    bus_start(); send_byte(8'hC3, ak);
    read_byte(1'b0, rb, oe);
    chk("R8 flag cleared by stop", int'(rb[7]), 0);
    bus_stop();

    // R5: repeated byte, resampled
    bus_start(); send_byte(8'hC3, ak);
    lock_in = 1'b0; port_lvl = 3'b111; conv_code = 3'd1;
    read_byte(1'b1, rb, oe);
    chk("R5 first byte", int'(rb), int'({1'b0, 1'b0, 3'b111, 3'd1}));
    lock_in = 1'b1; port_lvl = 3'b000; conv_code = 3'd6;
    read_byte(1'b1, rb, oe);
    chk("R5 repeated byte resampled", int'(rb), int'({1'b0, 1'b1, 3'b000, 3'd6}));
    conv_code = 3'd2;
    read_byte(1'b0, rb, oe);
    chk("R5 third byte", int'(rb), int'({1'b0, 1'b1, 3'b000, 3'd2}));
    // R6: after NACK, further clocks see no drive
    read_byte(1'b0, rb, oe);
    chk("R6 no drive after nack", int'(oe), 0);
    chk("R6 bus high after nack", int'(rb), 'hFF);
    bus_stop();

    // R9: repeated START in mid-address restarts reception
    bus_start();
    for (int i = 7; i >= 5; i--) begin
      sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0;
    end
    bus_start(); send_byte(8'hC3, ak);
    chk("R9 restart then ack", int'(ak), 1);
    read_byte(1'b0, rb, oe);
    chk("R9 byte after restart", int'(rb), int'({1'b0, 1'b1, 3'b000, 3'd2}));
    bus_stop();
    chk("R3 R6 idle released", int'(sda_oe), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule